// File: doc/BRIEF.md
# Deferred Fetch Fault Tracker

This block sits between instruction fetch and execute in a small in-order pipeline. When the fetch bus reports an error, no exception is raised at that moment. The fetched slot is marked as faulted, and the mark travels with the instruction through a short pipeline of registers. The instruction is never offered to execute as a valid instruction.

An abort request is raised only in the cycle when the faulted slot sits in the execute stage and the stage advances, so the abort is tied exactly to the instruction whose fetch failed. If a flush (for example from a taken branch) removes the slot first, the fault is dropped and leaves no trace. A taken abort clears every younger slot. It also loads three fault registers: the failed fetch address, a fault-type code, and an auxiliary code that says which memory the fault came from. Software reads these registers through a select-and-read port.

Top module: `fetch_fault_tracker`

## Requirements
- R1: After reset, `abort_req` and `ex_valid` are 0 and every read select returns 0.
- R2: A fetch with `fetch_err` high raises no abort in the cycle it is accepted or while it travels. When it reaches execute, `ex_valid` stays 0 for that slot.
- R3: A faulted fetch accepted in cycle k, with `advance` high in every cycle, produces `abort_req` = 1 in cycle k+3 and not before.
- R4: While `advance` is low, all pipeline slots and their fault marks are held, and a faulted slot in execute raises no abort until `advance` returns high.
- R5: A `flush` clears every pipeline slot at the next edge. A faulted slot removed this way never raises an abort, and the fault registers keep their old values.
- R6: If `flush` is high in the cycle when a faulted slot would abort, no abort is raised and the fault registers are not loaded.
- R7: `abort_req` lasts exactly one cycle. At the same edge it clears all younger slots, including a fetch presented in the abort cycle, so none of them reaches execute as valid or raises its own abort.
- R8: On a taken abort, the address register (read select 1) is loaded with the address of the failed fetch.
- R9: On a taken abort, the auxiliary register (read select 2) is loaded with the fault source code: 0 = none, 1 = tightly coupled memory A, 2 = tightly coupled memory B, 3 = system bus.
- R10: On a taken abort, the status register (read select 0) is loaded with the fault-type code supplied with the fetch error.
- R11: The fault registers hold their values until the next taken abort. Read select 3 returns 0, and narrower fields are zero-extended onto `rd_data`.
- R12: Fault-free fetches reach execute in order, three accepted advances later, with `ex_valid` = 1 and `ex_data` equal to the fetched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | A fetch result is presented |
| fetch_addr | input | ADDR_W | Address of the fetch |
| fetch_data | input | DATA_W | Fetched instruction word |
| fetch_err | input | 1 | Fetch bus reported an error |
| fetch_src | input | 2 | Fault source code (see R9) |
| fetch_type | input | TYPE_W | Fault-type code |
| advance | input | 1 | Pipeline and execute stage advance this cycle |
| flush | input | 1 | Remove all slots in flight |
| abort_req | output | 1 | Precise abort pulse for the slot in execute |
| ex_valid | output | 1 | Execute holds a valid, fault-free instruction |
| ex_data | output | DATA_W | Instruction word in execute |
| rd_sel | input | 2 | Fault register select |
| rd_data | output | ADDR_W | Selected fault register, zero-extended |

## Verification
The assertions rely on a few input conditions. Reset is synchronous and held for at least one edge. `fetch_err` only has meaning together with `fetch_valid`. A fetch presented while `advance` is low is simply not taken, so the fetch side must present it again. The stimulus follows these rules: it drives every input on the falling edge, raises errors only on valid fetches, and keeps `fetch_valid` low during stalls. Each stall, flush and abort therefore lands on a known slot, and the pulse timing can be predicted by counting accepted advances.

// File: rtl/fft_pkg.sv
// Shared codes for the deferred fetch fault tracker.
// Assumes the source code field is two bits wide on every user.
package fft_pkg;
    localparam int SRC_W = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE   = 2'd0,
        SRC_TCM_A  = 2'd1,
        SRC_TCM_B  = 2'd2,
        SRC_SYSBUS = 2'd3
    } fault_src_e;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ADDR   = 2'd1,
        SEL_AUX    = 2'd2,
        SEL_NONE   = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/fft_stage.sv
// One pipeline slot: valid bit, fault mark and payload.
// Assumes kill has priority over enable; payload is left as is on kill
// because nothing reads it while valid is low.
module fft_stage #(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             kill,
    input  logic             in_valid,
    input  logic             in_fault,
    input  logic [PAY_W-1:0] in_pay,
    output logic             out_valid,
    output logic             out_fault,
    output logic [PAY_W-1:0] out_pay
);
    // Valid and fault mark: cleared by reset or kill, loaded on enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
        end else if (kill) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
        end else if (en) begin
            out_valid <= in_valid;
            out_fault <= in_fault;
        end
    end

    // Payload: loaded on enable, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_pay <= '0;
        else if (en && !kill)
            out_pay <= in_pay;
    end
endmodule

// File: rtl/fft_fault_regs.sv
// Fault capture registers and their read port.
// Assumes cap_en is high for exactly the cycle of a taken abort and
// that ADDR_W is wider than the type and source fields.
module fft_fault_regs
    import fft_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TYPE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [SRC_W-1:0]  cap_src,
    input  logic [TYPE_W-1:0] cap_type,
    input  logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data
);
    logic [ADDR_W-1:0] addr_q;
    logic [SRC_W-1:0]  aux_q;
    logic [TYPE_W-1:0] status_q;

    // Load all three fields together on a taken abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            aux_q    <= '0;
            status_q <= '0;
        end else if (cap_en) begin
            addr_q   <= cap_addr;
            aux_q    <= cap_src;
            status_q <= cap_type;
        end
    end

    // Read mux with zero extension of the narrow fields.
    always_comb begin
        case (rd_sel_e'(rd_sel))
            SEL_STATUS: rd_data = {{(ADDR_W-TYPE_W){1'b0}}, status_q};
            SEL_ADDR:   rd_data = addr_q;
            SEL_AUX:    rd_data = {{(ADDR_W-SRC_W){1'b0}}, aux_q};
            default:    rd_data = '0;
        endcase
    end

    assert_capture_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (addr_q == $past(cap_addr)) && (aux_q == $past(cap_src))
                   && (status_q == $past(cap_type)));

    assert_regs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(addr_q) && $stable(aux_q) && $stable(status_q));
endmodule

// File: rtl/fetch_fault_tracker.sv
// Deferred fetch fault tracker: carries a fault mark with each fetched
// slot through DEPTH stages and raises a precise abort only when the
// faulted slot executes. Assumes fetch is presented again if it is
// offered while advance is low, and that flush outranks abort.
module fetch_fault_tracker
    import fft_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TYPE_W = 4,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [DATA_W-1:0] fetch_data,
    input  logic              fetch_err,
    input  logic [1:0]        fetch_src,
    input  logic [TYPE_W-1:0] fetch_type,
    input  logic              advance,
    input  logic              flush,
    output logic              abort_req,
    output logic              ex_valid,
    output logic [DATA_W-1:0] ex_data,
    input  logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data
);
    localparam int PAY_W = TYPE_W + SRC_W + ADDR_W + DATA_W;

    logic [DEPTH:0]   v;
    logic [DEPTH:0]   f;
    logic [PAY_W-1:0] p [0:DEPTH];
    logic             kill;

    logic [ADDR_W-1:0] ex_addr;
    logic [SRC_W-1:0]  ex_src;
    logic [TYPE_W-1:0] ex_type;

    // Entry point: the fault mark only counts on a valid fetch.
    assign v[0] = fetch_valid;
    assign f[0] = fetch_valid & fetch_err;
    assign p[0] = {fetch_type, fetch_src, fetch_addr, fetch_data};

    // Chain of identical slots from fetch to execute.
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        fft_stage #(.PAY_W(PAY_W)) stage_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (advance),
            .kill     (kill),
            .in_valid (v[i]),
            .in_fault (f[i]),
            .in_pay   (p[i]),
            .out_valid(v[i+1]),
            .out_fault(f[i+1]),
            .out_pay  (p[i+1])
        );
    end

    // Split the execute slot back into its fields.
    assign {ex_type, ex_src, ex_addr, ex_data} = p[DEPTH];

    // Abort only when the faulted slot would actually execute.
    assign abort_req = v[DEPTH] & f[DEPTH] & advance & ~flush;
    assign kill      = flush | abort_req;
    assign ex_valid  = v[DEPTH] & ~f[DEPTH];

    fft_fault_regs #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (abort_req),
        .cap_addr(ex_addr),
        .cap_src (ex_src),
        .cap_type(ex_type),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    assert_flush_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (v[DEPTH:1] == '0) && (f[DEPTH:1] == '0));

    assert_abort_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !abort_req);

    assert_abort_kills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (v[DEPTH:1] == '0));

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !flush) |=> $stable(v[DEPTH:1]) && $stable(f[DEPTH:1]));
endmodule

// File: tb/fetch_fault_tracker_tb_top.sv
module fetch_fault_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_valid;
    logic [31:0] fetch_addr;
    logic [31:0] fetch_data;
    logic        fetch_err;
    logic [1:0]  fetch_src;
    logic [3:0]  fetch_type;
    logic        advance;
    logic        flush;
    logic        abort_req;
    logic        ex_valid;
    logic [31:0] ex_data;
    logic [1:0]  rd_sel;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    fetch_fault_tracker dut_i (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .fetch_err(fetch_err), .fetch_src(fetch_src), .fetch_type(fetch_type),
        .advance(advance), .flush(flush),
        .abort_req(abort_req), .ex_valid(ex_valid), .ex_data(ex_data),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs on the falling edge.
    task automatic drive(input logic fv, input logic [31:0] a, input logic [31:0] d,
                         input logic err, input logic [1:0] src, input logic [3:0] typ,
                         input logic adv, input logic fl);
        @(negedge clk);
        fetch_valid = fv; fetch_addr = a; fetch_data = d;
        fetch_err = err; fetch_src = src; fetch_type = typ;
        advance = adv; flush = fl;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 4'd0, 1'b1, 1'b0);
    endtask

    task automatic read_reg(input logic [1:0] sel, output logic [31:0] val);
        rd_sel = sel;
        #1;
        val = rd_data;
    endtask

    task automatic check_regs(input string req, input logic [31:0] st,
                              input logic [31:0] ad, input logic [31:0] ax);
        logic [31:0] r;
        read_reg(2'd0, r); check({req, " status"}, r, st);
        read_reg(2'd1, r); check({req, " addr"}, r, ad);
        read_reg(2'd2, r); check({req, " aux"}, r, ax);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        rst_n = 1'b0;
        idle(); idle();
        check("R1 abort", {31'b0, abort_req}, 32'd0);
        check("R1 ex_valid", {31'b0, ex_valid}, 32'd0);
        rst_n = 1'b1;
        idle();
        check_regs("R1", 32'd0, 32'd0, 32'd0);
        read_reg(2'd3, r); check("R1 sel3", r, 32'd0);
    endtask

    task automatic t_clean_flow();
        drive(1'b1, 32'h40, 32'hA0A0_0001, 1'b0, 2'd0, 4'd0, 1'b1, 1'b0);
        drive(1'b1, 32'h44, 32'hA0A0_0002, 1'b0, 2'd0, 4'd0, 1'b1, 1'b0);
        drive(1'b1, 32'h48, 32'hA0A0_0003, 1'b0, 2'd0, 4'd0, 1'b1, 1'b0);
        for (int i = 1; i <= 3; i++) begin
            idle();
            check("R12 ex_valid", {31'b0, ex_valid}, 32'd1);
            check("R12 ex_data", ex_data, 32'hA0A0_0000 + i);
            check("R12 no abort", {31'b0, abort_req}, 32'd0);
        end
        idle();
        check("R12 drained", {31'b0, ex_valid}, 32'd0);
    endtask

    task automatic t_fault_taken();
        drive(1'b1, 32'h0000_1100, 32'hDEAD_0001, 1'b1, 2'd1, 4'd5, 1'b1, 1'b0);
        check("R2 no abort at fetch", {31'b0, abort_req}, 32'd0);
        idle(); check("R2 no abort k+1", {31'b0, abort_req}, 32'd0);
        idle(); check("R2 no abort k+2", {31'b0, abort_req}, 32'd0);
        idle();
        check("R3 abort at k+3", {31'b0, abort_req}, 32'd1);
        check("R2 faulted not valid", {31'b0, ex_valid}, 32'd0);
        idle();
        check("R7 one-cycle pulse", {31'b0, abort_req}, 32'd0);
        check_regs("R8 R9 R10 tcm A", 32'd5, 32'h0000_1100, 32'd1);
    endtask

    task automatic t_stall();
        drive(1'b1, 32'h0000_2200, 32'h0, 1'b1, 2'd2, 4'd3, 1'b1, 1'b0);
        idle(); idle();
        drive(1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0);
        check("R4 stalled no abort", {31'b0, abort_req}, 32'd0);
        drive(1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0);
        check("R4 still stalled", {31'b0, abort_req}, 32'd0);
        idle();
        check("R4 abort after stall", {31'b0, abort_req}, 32'd1);
        idle();
        check_regs("R9 tcm B", 32'd3, 32'h0000_2200, 32'd2);
    endtask

    task automatic t_flush_early();
        drive(1'b1, 32'h0000_3300, 32'h0, 1'b1, 2'd3, 4'd7, 1'b1, 1'b0);
        idle();
        drive(1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 4'd0, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) begin
            idle();
            check("R5 no abort after flush", {31'b0, abort_req}, 32'd0);
        end
        check_regs("R5 regs kept", 32'd3, 32'h0000_2200, 32'd2);
    endtask

    task automatic t_flush_same_cycle();
        drive(1'b1, 32'h0000_4400, 32'h0, 1'b1, 2'd1, 4'd6, 1'b1, 1'b0);
        idle(); idle();
        drive(1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 4'd0, 1'b1, 1'b1);
        check("R6 flush suppresses abort", {31'b0, abort_req}, 32'd0);
        idle(); check("R6 no late abort", {31'b0, abort_req}, 32'd0);
        idle(); check("R6 no late abort 2", {31'b0, abort_req}, 32'd0);
        check_regs("R6 regs kept", 32'd3, 32'h0000_2200, 32'd2);
    endtask

    task automatic t_kill_younger();
        logic [31:0] r;
        drive(1'b1, 32'h0000_5500, 32'h0, 1'b1, 2'd3, 4'd9, 1'b1, 1'b0);
        drive(1'b1, 32'h0000_5504, 32'h0, 1'b1, 2'd1, 4'd2, 1'b1, 1'b0);
        drive(1'b1, 32'h0000_5508, 32'hBEEF_0001, 1'b0, 2'd0, 4'd0, 1'b1, 1'b0);
        drive(1'b1, 32'h0000_550C, 32'hBEEF_0002, 1'b0, 2'd0, 4'd0, 1'b1, 1'b0);
        check("R7 first fault aborts", {31'b0, abort_req}, 32'd1);
        for (int i = 0; i < 4; i++) begin
            idle();
            check("R7 younger killed abort", {31'b0, abort_req}, 32'd0);
            check("R7 younger killed valid", {31'b0, ex_valid}, 32'd0);
        end
        check_regs("R8 R9 R10 system bus", 32'd9, 32'h0000_5500, 32'd3);
        for (int i = 0; i < 5; i++) idle();
        check_regs("R11 hold", 32'd9, 32'h0000_5500, 32'd3);
        read_reg(2'd3, r); check("R11 sel3 zero", r, 32'd0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; rd_sel = 2'd0;
        fetch_valid = 1'b0; fetch_addr = '0; fetch_data = '0; fetch_err = 1'b0;
        fetch_src = '0; fetch_type = '0; advance = 1'b0; flush = 1'b0;
        t_reset();
        t_clean_flow();
        t_fault_taken();
        t_stall();
        t_flush_early();
        t_flush_same_cycle();
        t_kill_younger();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end
endmodule